// File: doc/BRIEF.md
# Multi-Lane Byte Merger

This block sits behind a set of parallel receive lanes and rebuilds the single byte stream that a transmitter striped across them. The transmitter deals the bytes of a packet out to the lanes in rotation. Lane 0 takes the first byte, the next lane takes the next byte, and the rotation wraps after the highest active lane. The block accepts between one and eight active lanes, and a run-time input sets how many are in use. Each lane gives the block one byte at a time, together with a valid flag, a flag marking the lane's first byte of the packet and a flag marking its last byte. The lanes can arrive skewed relative to each other by a few cycles.

A packet starts on every active lane at once, so the block uses that shared start as its alignment point. Each lane writes into its own small FIFO, beginning with its start byte. The merged output stays idle until every active lane has reported its start. The block then reads the FIFO heads in rotation and sends out one byte per cycle, with valid and last flags, under a downstream ready signal. A packet length need not be a multiple of the lane count. In that case the final rotation is partial, and the last-byte flag goes on the byte that closes the packet. If the lanes fail to line up within the permitted skew, or a lane FIFO overflows, the block raises a one-cycle error, drops the packet and waits for a fresh start. A header failure reported from downstream also sends the block back to waiting.

Top module: `lane_byte_merger`

## Requirements
- R1: Only lanes 0 to laneCount-1 are active. Any activity on the other lanes, including their start flags, has no effect on the output.
- R2: The output carries every byte of a packet exactly once, in original serial order. Lane 0 is read first, and the reader then rotates through the active lanes.
- R3: outValid stays low until every active lane has delivered its start byte. It first rises the cycle after the most-skewed lane's start is taken.
- R4: If the latest active start arrives at most SKEW_MAX (default 3) cycles after the earliest one, the packet is accepted without error.
- R5: If an active lane's start arrives more than SKEW_MAX cycles after the earliest start, alignErr pulses high for one cycle. The packet is then dropped and produces no output bytes.
- R6: outLast is high on the final byte of the packet and on no other byte, including when the length is not a multiple of the lane count. After that byte is accepted, outValid is low in the next cycle.
- R7: A cycle with hdrFail high returns the block to waiting for a new start. Buffered bytes are discarded, and outValid stays low until a later packet has aligned.
- R8: While outValid is high and outReady is low, outValid and outData hold their values until the byte is accepted.
- R9: If a byte arrives on a lane whose FIFO (FIFO_DEPTH entries, default 4) is full and is not being read in that cycle, alignErr pulses and the packet is dropped.
- R10: During reset and just after it, outValid and alignErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneCount | input | 4 | Number of active lanes, 1 to LANES |
| laneValid | input | LANES | Per-lane byte valid |
| laneStart | input | LANES | Per-lane first byte of packet |
| laneEnd | input | LANES | Per-lane last byte of packet |
| laneData | input | 8*LANES | Per-lane byte, lane i in bits 8i+7:8i |
| hdrFail | input | 1 | Downstream header check failed |
| outReady | input | 1 | Downstream can take a byte |
| outData | output | 8 | Merged byte |
| outValid | output | 1 | outData holds a byte |
| outLast | output | 1 | Final byte of the packet |
| alignErr | output | 1 | One-cycle pulse on skew or overflow failure |

## Verification
The assertions take the following for granted about the inputs:
- every active lane carries at least one byte, so a packet is at least laneCount bytes long;
- laneCount does not change within a packet;
- each lane delivers at most one byte every laneCount cycles, which is the round-robin drain rate;
- a new packet starts only after the previous one has ended or been dropped.

The stimulus generator follows these rules. It derives every lane's byte timing from the striping rule, at exactly that rate, shifted by a per-lane delay, and it leaves idle cycles between packets. Only the overflow test breaks the rate assumption, and it does so on purpose, by holding outReady low.

// File: rtl/lane_merge_pkg.sv
package lane_merge_pkg;
  localparam int LANE_CAP = 8;
  localparam int SEL_W = $clog2(LANE_CAP);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_RUN   = 2'd2
  } mrg_state_e;

  typedef struct packed {
    logic             flush;
    logic             pop;
    logic [SEL_W-1:0] sel;
  } mrg_strobe_t;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              pushOk, popOk;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign pushOk   = push && (!full || pop);
  assign popOk    = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [ADDR_W-1:0] nextPtr(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
    end
  end

  // R9: occupancy never exceeds the depth
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R9: a write into a full, unread FIFO must be met by the control's flush
  a_r9_overflow_flush: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |-> flush);
endmodule

// File: rtl/lane_merge_datapath.sv
module lane_merge_datapath
  import lane_merge_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int WORD_W = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  mrg_strobe_t        strobe,
  input  logic [LANES-1:0]   pushEn,
  input  logic [8*LANES-1:0] laneData,
  input  logic [LANES-1:0]   laneEnd,
  output logic [LANES-1:0]   emptyVec,
  output logic [LANES-1:0]   fullVec,
  output logic               headEnd,
  output logic [7:0]         outData
);
  logic [WORD_W-1:0] heads [LANES];
  logic [WORD_W-1:0] headWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic popThis;
    assign popThis = strobe.pop && (strobe.sel == SEL_W'(g));
    lane_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) fifo_i (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (strobe.flush),
      .push     (pushEn[g]),
      .pushData ({laneEnd[g], laneData[8*g +: 8]}),
      .pop      (popThis),
      .headData (heads[g]),
      .empty    (emptyVec[g]),
      .full     (fullVec[g])
    );
  end

  always_comb begin
    headWord = '0;
    for (int i = 0; i < LANES; i++) begin
      if (strobe.sel == SEL_W'(i)) headWord = heads[i];
    end
  end

  assign outData = headWord[7:0];
  assign headEnd = headWord[8];
endmodule

// File: rtl/lane_merge_ctrl.sv
module lane_merge_ctrl
  import lane_merge_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int SKEW_MAX = 3,
  localparam int CNT_W   = $clog2(LANES + 1),
  localparam int SKEW_W  = $clog2(SKEW_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] laneCount,
  input  logic [LANES-1:0] laneValid,
  input  logic [LANES-1:0] laneStart,
  input  logic [LANES-1:0] laneEnd,
  input  logic             hdrFail,
  input  logic             outReady,
  input  logic [LANES-1:0] emptyVec,
  input  logic [LANES-1:0] fullVec,
  input  logic             headEnd,
  output mrg_strobe_t      strobe,
  output logic [LANES-1:0] pushEn,
  output logic             outValid,
  output logic             outLast,
  output logic             alignErr
);
  mrg_state_e        state;
  logic [LANES-1:0]  started, inDone, outDone, activeMask;
  logic [LANES-1:0]  reqMask, maskNow, startNow, startedNext, inDoneNext;
  logic [LANES-1:0]  selHot, popHot, others;
  logic [CNT_W-1:0]  activeCnt;
  logic [SEL_W-1:0]  rr;
  logic [SKEW_W-1:0] skewCnt;
  logic              allStarted, overflow, skewFail, pop, finish, drop;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      reqMask[i] = (CNT_W'(i) < laneCount);
      selHot[i]  = (rr == SEL_W'(i));
    end
  end

  // Lanes in use: sampled from laneCount while idle, frozen for the packet
  assign maskNow     = (state == ST_IDLE) ? reqMask : activeMask;
  assign startNow    = laneValid & laneStart & maskNow & ~started & {LANES{state != ST_RUN}};
  assign pushEn      = laneValid & maskNow & ~inDone & (started | startNow);
  assign startedNext = started | startNow;
  assign allStarted  = &(startedNext | ~maskNow);
  assign inDoneNext  = inDone | (pushEn & laneEnd);

  assign outValid = (state == ST_RUN) && |(~emptyVec & selHot);
  assign pop      = outValid && outReady;
  assign popHot   = selHot & {LANES{pop}};
  assign overflow = |(pushEn & fullVec & ~popHot);
  assign skewFail = (state == ST_ALIGN) && !allStarted && (skewCnt == SKEW_W'(SKEW_MAX));

  // Final byte: its lane's end and every other active lane's end already sent
  assign others  = activeMask & ~selHot;
  assign outLast = outValid && headEnd && ((outDone & others) == others);
  assign finish  = pop && outLast;
  assign drop    = hdrFail || overflow || skewFail || finish;

  assign strobe.flush = drop;
  assign strobe.pop   = pop;
  assign strobe.sel   = rr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      started    <= '0;
      inDone     <= '0;
      outDone    <= '0;
      activeMask <= '0;
      activeCnt  <= '0;
      rr         <= '0;
      skewCnt    <= '0;
      alignErr   <= 1'b0;
    end else begin
      alignErr <= !hdrFail && (overflow || skewFail);
      if (drop) begin
        state   <= ST_IDLE;
        started <= '0;
        inDone  <= '0;
        outDone <= '0;
        rr      <= '0;
        skewCnt <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (|startNow) begin
              activeMask <= reqMask;
              activeCnt  <= laneCount;
              started    <= startNow;
              inDone     <= inDoneNext;
              outDone    <= '0;
              rr         <= '0;
              skewCnt    <= SKEW_W'(1);
              state      <= allStarted ? ST_RUN : ST_ALIGN;
            end
          end
          ST_ALIGN: begin
            started <= startedNext;
            inDone  <= inDoneNext;
            skewCnt <= skewCnt + SKEW_W'(1);
            if (allStarted) state <= ST_RUN;
          end
          ST_RUN: begin
            inDone <= inDoneNext;
            if (pop) begin
              outDone <= outDone | (selHot & {LANES{headEnd}});
              rr      <= (int'(rr) + 1 >= int'(activeCnt)) ? '0 : rr + SEL_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R3: a byte is offered only once every active lane has started
  a_r3_all_started: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> &(started | ~activeMask));
  // R1: the selected lane is always one of the active lanes
  a_r1_sel_active: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> |(selHot & activeMask));
  // R5: the error is a single-cycle pulse
  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> !alignErr);
  // R6: nothing is offered right after the final byte is taken
  a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (pop && outLast) |=> !outValid);
  // R2: rotation pointer stays within the active lane count
  a_r2_rr_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> (int'(rr) < int'(activeCnt)));
endmodule

// File: rtl/lane_byte_merger.sv
module lane_byte_merger
  import lane_merge_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int SKEW_MAX   = 3,
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   laneCount,
  input  logic [LANES-1:0]   laneValid,
  input  logic [LANES-1:0]   laneStart,
  input  logic [LANES-1:0]   laneEnd,
  input  logic [8*LANES-1:0] laneData,
  input  logic               hdrFail,
  input  logic               outReady,
  output logic [7:0]         outData,
  output logic               outValid,
  output logic               outLast,
  output logic               alignErr
);
  mrg_strobe_t      strobe;
  logic [LANES-1:0] pushEn, emptyVec, fullVec;
  logic             headEnd;

  lane_merge_ctrl #(.LANES(LANES), .SKEW_MAX(SKEW_MAX)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .laneCount (laneCount),
    .laneValid (laneValid),
    .laneStart (laneStart),
    .laneEnd   (laneEnd),
    .hdrFail   (hdrFail),
    .outReady  (outReady),
    .emptyVec  (emptyVec),
    .fullVec   (fullVec),
    .headEnd   (headEnd),
    .strobe    (strobe),
    .pushEn    (pushEn),
    .outValid  (outValid),
    .outLast   (outLast),
    .alignErr  (alignErr)
  );

  lane_merge_datapath #(.LANES(LANES), .DEPTH(FIFO_DEPTH)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushEn   (pushEn),
    .laneData (laneData),
    .laneEnd  (laneEnd),
    .emptyVec (emptyVec),
    .fullVec  (fullVec),
    .headEnd  (headEnd),
    .outData  (outData)
  );

  // R8: a stalled byte is held until taken (unless the packet is dropped)
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !hdrFail) |=> (alignErr || (outValid && $stable(outData))));
endmodule

// File: tb/lane_byte_merger_tb.sv
`timescale 1ns/1ps
module lane_byte_merger_tb_top;
  typedef struct packed {
    logic [3:0]  lanes;
    logic [7:0]  len;
    logic [31:0] delays;   // nibble i = start delay of lane i
    logic [7:0]  readyPat; // bit (cycle % 8) drives outReady
    logic [7:0]  seed;
    logic        noise;    // drive junk with start flags on inactive lanes
    logic        expErr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 8'd5,  32'h0,        8'hFF, 8'h10, 1'b0, 1'b0},
    '{4'd4, 8'd8,  32'h0,        8'hFF, 8'h20, 1'b0, 1'b0},
    '{4'd4, 8'd10, 32'h3210,     8'hFF, 8'h30, 1'b0, 1'b0},
    '{4'd8, 8'd19, 32'h31203102, 8'hF7, 8'h40, 1'b0, 1'b0},
    '{4'd3, 8'd7,  32'h102,      8'hDD, 8'h50, 1'b0, 1'b0},
    '{4'd2, 8'd9,  32'h03,       8'hFF, 8'h60, 1'b1, 1'b0},
    '{4'd5, 8'd5,  32'h0,        8'hFF, 8'h70, 1'b0, 1'b0},
    '{4'd4, 8'd12, 32'h0400,     8'hFF, 8'h80, 1'b0, 1'b1},
    '{4'd6, 8'd23, 32'h123012,   8'hFE, 8'h90, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  laneCount = 4'd1;
  logic [7:0]  laneValid = '0, laneStart = '0, laneEnd = '0;
  logic [63:0] laneData = '0;
  logic        hdrFail = 1'b0, outReady = 1'b0;
  logic [7:0]  outData;
  logic        outValid, outLast, alignErr;

  int checks = 0, fails = 0;
  logic [7:0] gotData [64];
  int  nGot, nLast, lastPos, firstValid, validAfterHdr, stallBad, stallSeen;
  bit  errSeen;

  always #4 clk = ~clk;

  lane_byte_merger dut_i (
    .clk(clk), .rstN(rstN), .laneCount(laneCount), .laneValid(laneValid),
    .laneStart(laneStart), .laneEnd(laneEnd), .laneData(laneData),
    .hdrFail(hdrFail), .outReady(outReady), .outData(outData),
    .outValid(outValid), .outLast(outLast), .alignErr(alignErr)
  );

  function automatic logic [7:0] expByte(input logic [7:0] seed, input int idx);
    return seed + 8'(idx * 7);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic runPacket(input vec_t v, input int hdrAt);
    int L = int'(v.lanes);
    int N = int'(v.len);
    bit prevStall = 1'b0;
    logic [7:0] prevData = '0;
    logic [7:0] vV, vS, vE;
    logic [63:0] vD;
    nGot = 0; nLast = 0; lastPos = -1; firstValid = -1;
    validAfterHdr = 0; stallBad = 0; stallSeen = 0; errSeen = 1'b0;
    for (int c = 0; c < 3 * N + 40; c++) begin
      @(negedge clk);
      vV = '0; vS = '0; vE = '0; vD = '0;
      for (int i = 0; i < 8; i++) begin
        int d = int'(v.delays[4*i +: 4]);
        if (i < L) begin
          int rel = c - d;
          if (rel >= 0 && rel % L == 0) begin
            int k = rel / L;
            int idx = i + k * L;
            if (idx < N) begin
              vV[i] = 1'b1;
              vS[i] = (k == 0);
              vE[i] = (idx + L >= N);
              vD[8*i +: 8] = expByte(v.seed, idx);
            end
          end
        end else if (v.noise) begin
          vV[i] = 1'b1; vS[i] = 1'b1; vE[i] = 1'b1; vD[8*i +: 8] = 8'hEE;
        end
      end
      laneCount = v.lanes; laneValid = vV; laneStart = vS; laneEnd = vE; laneData = vD;
      hdrFail  = (c == hdrAt);
      outReady = v.readyPat[c % 8];
      #1;
      if (alignErr) errSeen = 1'b1;
      if (outValid && firstValid < 0) firstValid = c;
      if (hdrAt >= 0 && c > hdrAt && outValid) validAfterHdr++;
      if (prevStall && outValid) begin
        stallSeen++;
        if (outData != prevData) stallBad++;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (outValid && outReady) begin
        if (outLast) begin nLast++; lastPos = nGot; end
        if (nGot < 64) gotData[nGot] = outData;
        nGot++;
      end
    end
    @(negedge clk);
    laneValid = '0; laneStart = '0; laneEnd = '0; laneData = '0;
    hdrFail = 1'b0; outReady = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkGood(input vec_t v, input string orderReq);
    int N = int'(v.len);
    int maxD = 0;
    for (int i = 0; i < int'(v.lanes); i++)
      if (int'(v.delays[4*i +: 4]) > maxD) maxD = int'(v.delays[4*i +: 4]);
    chk(nGot == N, "R2", "byte count", nGot, N);
    for (int j = 0; j < N && j < nGot; j++)
      chk(gotData[j] == expByte(v.seed, j), orderReq, $sformatf("byte %0d", j),
          int'(gotData[j]), int'(expByte(v.seed, j)));
    chk(nLast == 1 && lastPos == N - 1, "R6", "last flag position", lastPos, N - 1);
    chk(!errSeen, "R4", "alignErr within allowed skew", int'(errSeen), 0);
    chk(firstValid == maxD + 1, "R3", "first valid cycle", firstValid, maxD + 1);
    if (stallSeen > 0) chk(stallBad == 0, "R8", "data held while stalled", stallBad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0, "R10", "outValid in reset", int'(outValid), 0);
    chk(alignErr == 1'b0, "R10", "alignErr in reset", int'(alignErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0, "R10", "outValid after reset", int'(outValid), 0);
    chk(alignErr == 1'b0, "R10", "alignErr after reset", int'(alignErr), 0);
    repeat (2) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R6 R8
    for (int vi = 0; vi < NV; vi++) begin
      runPacket(VECS[vi], -1);
      if (VECS[vi].expErr) begin
        chk(errSeen, "R5", "alignErr on excess skew", int'(errSeen), 1);
        chk(nGot == 0, "R5", "bytes out after skew error", nGot, 0);
      end else begin
        checkGood(VECS[vi], VECS[vi].noise ? "R1" : "R2");
      end
    end

    // R7: header failure in mid-packet, then recovery
    runPacket('{4'd4, 8'd16, 32'h0, 8'hFF, 8'hA0, 1'b0, 1'b0}, 6);
    chk(validAfterHdr == 0, "R7", "valid cycles after hdrFail", validAfterHdr, 0);
    chk(nGot > 0, "R7", "bytes before hdrFail", nGot, 6);
    runPacket(VECS[2], -1);
    checkGood(VECS[2], "R7");

    // R9: FIFO overflow with output held off
    runPacket('{4'd1, 8'd12, 32'h0, 8'h00, 8'hB0, 1'b0, 1'b0}, -1);
    chk(errSeen, "R9", "alignErr on overflow", int'(errSeen), 1);
    chk(nGot == 0, "R9", "bytes out on overflow", nGot, 0);
    chk(outValid == 1'b0, "R9", "outValid after overflow drop", int'(outValid), 0);
    runPacket(VECS[1], -1);
    checkGood(VECS[1], "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule